// File: doc/BRIEF.md
# Interleaved DRAM Bank Sequencer

This block takes read and write requests, each for one 32-byte cache line, and sends each one to one of four DRAM banks. Each bank is controlled on its own. The two lowest bits of the line address pick the bank, so a run of consecutive lines moves through the banks in turn. Every bank has its own cycle timer. The banks are grouped in pairs on two separate data buses, so accesses to different banks can overlap and two transfers can be in flight at once. The bank cycle is five clocks in fast-page timing and four clocks in extended-data-out timing. The `edo_mode` input chooses between them, and its value is sampled when a request is accepted.

A write must be a full line or a half line. Smaller writes are answered with an error one cycle later and never reach a bank; the client has to carry them out as a read-modify-write. Reads finish in bank order but return in the order they were accepted, each with its request ID. A four-entry reorder buffer holds them until then.

Top module: `ilv_bank_seq`

## Requirements
- R1: After reset, `req_ready` is high for an idle read, and `rd_valid`, `err_valid` and `iss_valid` are low.
- R2: Each accepted legal request gives one `iss_valid` pulse in the cycle after acceptance. That pulse carries the line address, the write flag and `iss_bank` = line address bits [1:0].
- R3: With `edo_mode` low at acceptance, a bank stays busy for 5 clocks. Two requests to the same bank are accepted at least 5 cycles apart, and a read's `rd_valid` comes 5 cycles after its acceptance edge.
- R4: With `edo_mode` high at acceptance, the bank cycle is 4 clocks. Same-bank acceptances are 4 cycles apart and read latency is 4 cycles.
- R5: Banks 0 and 2 share bus A, and banks 1 and 3 share bus B. After an issue on a bus, the next issue on that same bus waits at least 2 cycles. Issues on different buses can be on consecutive cycles.
- R6: A stream of lines 0,1,2,3,0 in fast-page timing is accepted on cycles 0,1,2,3,5. While bank 0 is busy, banks 1 to 3 are still served.
- R7: Writes with `req_size` 2'b00 (32 bytes) or 2'b01 (16 bytes) go to their bank and produce no read response.
- R8: A write with `req_size` 2'b10 (8 bytes) or 2'b11 (4 bytes or less) is accepted even when its bank is busy. It raises `err_valid` with its ID in the next cycle and produces no `iss_valid`.
- R9: Read responses leave on `rd_valid`/`rd_id` in the order the reads were accepted, with the ID each read carried.
- R10: No more than 4 reads are outstanding. A fifth read stalls until the oldest one has returned, so in the stream 0,1,2,3,0 of reads the fifth is accepted 6 cycles after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edo_mode | input | 1 | 1 selects the 4-clock bank cycle, 0 selects the 5-clock cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | Write size code: 00 = 32 B, 01 = 16 B, 10 = 8 B, 11 = 4 B or less |
| req_line | input | LINE_AW | Cache-line address |
| req_id | input | ID_W | Request tag |
| iss_valid | output | 1 | Bank access started |
| iss_bank | output | 2 | Bank that was started |
| iss_write | output | 1 | Started access is a write |
| iss_line | output | LINE_AW | Line address of the started access |
| rd_valid | output | 1 | Read response |
| rd_id | output | ID_W | Tag of the read response |
| err_valid | output | 1 | Unsupported write size rejected |
| err_id | output | ID_W | Tag of the rejected write |

## Verification
The assertions check the following on every cycle:
- two issues never land on the same data bus in consecutive cycles;
- an undersized write is always accepted and always answered with an error rather than a bank issue;
- every accepted read starts a read access;
- the reorder buffer never holds more than its depth.

The cycle-exact values can only be shown by the bench scenarios: the bank cycle length in each timing mode, the read latency, the interleaved stream spacing, the stall caused by the full reorder buffer, and the in-order return of tags. The bench checks each of these against a scoreboard of expected issues, responses and errors.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned BANKS  = 4;
  localparam int unsigned BANK_W = 2;
  localparam int unsigned BUSES  = 2;

  typedef enum logic [1:0] {
    SZ_LINE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_QUAD = 2'b10,
    SZ_TINY = 2'b11
  } wr_size_e;
endpackage

// File: rtl/ilv_down_cnt.sv
module ilv_down_cnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign last = (cnt == W'(1));
endmodule

// File: rtl/ilv_rob.sv
module ilv_rob #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ID_W  = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic [ID_W-1:0]  alloc_id,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W:0]   occ,
  input  logic [DEPTH-1:0] done_set,
  output logic             rsp_valid,
  output logic [ID_W-1:0]  rsp_id
);
  // DEPTH is a power of two so the pointers wrap naturally.
  logic [ID_W-1:0]  id_mem [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [IDX_W-1:0] head;
  logic             pop;
  logic [DEPTH-1:0] pop_mask;

  assign pop      = (occ != '0) && done_q[head];
  assign pop_mask = pop ? (DEPTH'(1) << head) : '0;

  always_ff @(posedge clk) begin
    if (alloc) id_mem[tail_idx] <= alloc_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      tail_idx  <= '0;
      occ       <= '0;
      done_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
    end else begin
      done_q    <= (done_q | done_set) & ~pop_mask;
      rsp_valid <= pop;
      if (pop) begin
        rsp_id <= id_mem[head];
        head   <= head + 1'b1;
      end
      if (alloc) tail_idx <= tail_idx + 1'b1;
      occ <= occ + (IDX_W+1)'(alloc) - (IDX_W+1)'(pop);
    end
  end
endmodule

// File: rtl/ilv_bank_seq.sv
module ilv_bank_seq
  import ilv_pkg::*;
#(
  parameter int unsigned LINE_AW   = 20,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned FPM_CYC   = 5,
  parameter int unsigned EDO_CYC   = 4,
  parameter int unsigned XFER_CYC  = 2,
  parameter int unsigned ROB_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               edo_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [LINE_AW-1:0] req_line,
  input  logic [ID_W-1:0]    req_id,
  output logic               iss_valid,
  output logic [BANK_W-1:0]  iss_bank,
  output logic               iss_write,
  output logic [LINE_AW-1:0] iss_line,
  output logic               rd_valid,
  output logic [ID_W-1:0]    rd_id,
  output logic               err_valid,
  output logic [ID_W-1:0]    err_id
);
  localparam int unsigned MAX_CYC = (FPM_CYC > EDO_CYC) ? FPM_CYC : EDO_CYC;
  localparam int unsigned MAX_ALL = (MAX_CYC > XFER_CYC) ? MAX_CYC : XFER_CYC;
  localparam int unsigned CNT_W   = (MAX_ALL > 2) ? $clog2(MAX_ALL) : 1;
  localparam int unsigned RIDX_W  = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1;

  logic [BANK_W-1:0] sel;
  logic              size_ok, bad_wr, accept, go, rob_full;
  logic [CNT_W-1:0]  bank_len;
  logic [BANKS-1:0]  bank_busy, bank_last;
  logic [BUSES-1:0]  bus_busy, bus_last;
  logic [RIDX_W-1:0] rob_tail;
  logic [RIDX_W:0]   rob_occ;
  logic [ROB_DEPTH-1:0] done_set;
  logic [BANKS-1:0]  pend_rd;
  logic [RIDX_W-1:0] pend_idx [BANKS];

  assign sel      = req_line[BANK_W-1:0];
  assign size_ok  = (req_size == SZ_LINE) || (req_size == SZ_HALF);
  assign bad_wr   = req_write && !size_ok;
  assign rob_full = (rob_occ == (RIDX_W+1)'(ROB_DEPTH));
  assign req_ready = bad_wr ||
                     (!bank_busy[sel] && !bus_busy[sel[0]] && (req_write || !rob_full));
  assign accept   = req_valid && req_ready;
  assign go       = accept && !bad_wr;
  assign bank_len = edo_mode ? CNT_W'(EDO_CYC - 1) : CNT_W'(FPM_CYC - 1);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = go && (sel == BANK_W'(b));

    ilv_down_cnt #(.W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .load(hit), .load_val(bank_len),
      .busy(bank_busy[b]), .last(bank_last[b])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_rd[b]  <= 1'b0;
        pend_idx[b] <= '0;
      end else if (hit) begin
        pend_rd[b]  <= !req_write;
        pend_idx[b] <= rob_tail;
      end else if (bank_last[b]) begin
        pend_rd[b]  <= 1'b0;
      end
    end
  end

  for (genvar u = 0; u < BUSES; u++) begin : g_bus
    ilv_down_cnt #(.W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .load(go && (sel[0] == 1'(u))),
      .load_val(CNT_W'(XFER_CYC - 1)),
      .busy(bus_busy[u]), .last(bus_last[u])
    );
  end

  always_comb begin
    done_set = '0;
    for (int b = 0; b < BANKS; b++)
      if (bank_last[b] && pend_rd[b]) done_set[pend_idx[b]] = 1'b1;
  end

  ilv_rob #(.DEPTH(ROB_DEPTH), .ID_W(ID_W)) u_rob (
    .clk(clk), .rst(rst), .alloc(go && !req_write), .alloc_id(req_id),
    .tail_idx(rob_tail), .occ(rob_occ), .done_set(done_set),
    .rsp_valid(rd_valid), .rsp_id(rd_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_bank  <= '0;
      iss_write <= 1'b0;
      iss_line  <= '0;
      err_valid <= 1'b0;
      err_id    <= '0;
    end else begin
      iss_valid <= go;
      iss_bank  <= sel;
      iss_write <= req_write;
      iss_line  <= req_line;
      err_valid <= accept && bad_wr;
      err_id    <= req_id;
    end
  end

  logic unused_ok;
  assign unused_ok = ^bus_last;
endmodule

// File: rtl/ilv_bank_seq_chk.sv
module ilv_bank_seq_chk #(
  parameter int unsigned ROB_DEPTH = 4,
  localparam int unsigned RIDX_W = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [1:0]      req_size,
  input logic            iss_valid,
  input logic [1:0]      iss_bank,
  input logic            iss_write,
  input logic            err_valid,
  input logic [RIDX_W:0] rob_occ
);
  logic small_wr;
  assign small_wr = req_valid && req_write && req_size[1];

  p_bus_gap_r5: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> !(iss_valid && (iss_bank[0] == $past(iss_bank[0]))));

  p_small_ready_r8: assert property (@(posedge clk) disable iff (rst)
    small_wr |-> req_ready);

  p_small_err_r8: assert property (@(posedge clk) disable iff (rst)
    small_wr |=> (err_valid && !iss_valid));

  p_read_issue_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> (iss_valid && !iss_write));

  p_rob_bound_r10: assert property (@(posedge clk) disable iff (rst)
    rob_occ <= (RIDX_W+1)'(ROB_DEPTH));
endmodule

bind ilv_bank_seq ilv_bank_seq_chk #(.ROB_DEPTH(ROB_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_size(req_size), .iss_valid(iss_valid),
  .iss_bank(iss_bank), .iss_write(iss_write), .err_valid(err_valid),
  .rob_occ(rob_occ)
);

// File: tb/ilv_bank_seq_test.sv
module ilv_bank_seq_test;
  logic clk = 0, rst = 1, edo_mode = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [19:0] req_line = 0;
  logic [3:0] req_id = 0;
  logic req_ready, iss_valid, iss_write, rd_valid, err_valid;
  logic [1:0] iss_bank;
  logic [19:0] iss_line;
  logic [3:0] rd_id, err_id;

  int checks = 0, errors = 0, cyc = 0, last_rd = 0;
  logic [20:0] exp_iss[$];
  logic [3:0]  exp_rd[$];
  logic [3:0]  exp_err[$];

  always #2.5 clk = ~clk;

  ilv_bank_seq uut (
    .clk(clk), .rst(rst), .edo_mode(edo_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_line(req_line), .req_id(req_id), .iss_valid(iss_valid),
    .iss_bank(iss_bank), .iss_write(iss_write), .iss_line(iss_line),
    .rd_valid(rd_valid), .rd_id(rd_id), .err_valid(err_valid), .err_id(err_id)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) if (!rst) begin
    if (iss_valid) begin
      if (exp_iss.size() == 0) check(0, "R8 unexpected issue", int'(iss_line), -1);
      else begin
        logic [20:0] e;
        e = exp_iss.pop_front();
        check(iss_write == e[20] && iss_line == e[19:0], "R2 issue line/kind",
              int'({iss_write, iss_line}), int'(e));
        check(iss_bank == e[1:0], "R2 bank select", iss_bank, e[1:0]);
      end
    end
    if (rd_valid) begin
      last_rd = cyc;
      if (exp_rd.size() == 0) check(0, "R9 unexpected read response", rd_id, -1);
      else begin
        logic [3:0] e;
        e = exp_rd.pop_front();
        check(rd_id == e, "R9 read order/id", rd_id, e);
      end
    end
    if (err_valid) begin
      if (exp_err.size() == 0) check(0, "R8 unexpected error", err_id, -1);
      else begin
        logic [3:0] e;
        e = exp_err.pop_front();
        check(err_id == e, "R8 error id", err_id, e);
      end
    end
  end

  task automatic send(input logic w, input logic [1:0] sz, input logic [19:0] line,
                      input logic [3:0] id, output int acc);
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_line = line; req_id = id;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc = cyc;
    if (w && sz[1]) exp_err.push_back(id);
    else begin
      exp_iss.push_back({w, line});
      if (!w) exp_rd.push_back(id);
    end
  endtask

  task automatic idle_drain();
    @(negedge clk); req_valid = 0; req_write = 0; req_size = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
    summary();
  end

  initial begin
    int a, b, c, d, e, f;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);
    check(!rd_valid && !err_valid && !iss_valid, "R1 outputs idle",
          {rd_valid, err_valid, iss_valid}, 0);

    // R3 read latency in fast-page timing
    send(0, 0, 20'h00010, 4'd1, a);
    idle_drain();
    check(last_rd - a == 5, "R3 read latency", last_rd - a, 5);
    // R3/R7 same-bank writes, full then half
    send(1, 0, 20'h00004, 4'd2, a);
    send(1, 1, 20'h00008, 4'd3, b);
    idle_drain();
    check(b - a == 5, "R3 same bank spacing", b - a, 5);

    // R4 extended-data-out timing
    @(negedge clk); edo_mode = 1;
    send(0, 0, 20'h00001, 4'd4, a);
    idle_drain();
    check(last_rd - a == 4, "R4 read latency", last_rd - a, 4);
    send(1, 0, 20'h00005, 4'd5, a);
    send(1, 1, 20'h00009, 4'd6, b);
    idle_drain();
    check(b - a == 4, "R4 same bank spacing", b - a, 4);
    @(negedge clk); edo_mode = 0;

    // R5 bus sharing
    send(1, 0, 20'h00000, 4'd0, a);
    send(1, 0, 20'h00002, 4'd0, b);
    idle_drain();
    check(b - a == 2, "R5 same bus spacing", b - a, 2);
    send(1, 0, 20'h00000, 4'd0, a);
    send(1, 0, 20'h00001, 4'd0, b);
    idle_drain();
    check(b - a == 1, "R5 other bus spacing", b - a, 1);

    // R6 interleaved write stream 0,1,2,3,0 (R7: no read responses expected)
    send(1, 0, 20'h00100, 4'd0, a);
    send(1, 1, 20'h00101, 4'd0, b);
    send(1, 0, 20'h00102, 4'd0, c);
    send(1, 1, 20'h00103, 4'd0, d);
    send(1, 0, 20'h00104, 4'd0, e);
    idle_drain();
    check(b - a == 1 && c - a == 2 && d - a == 3, "R6 stream banks 1-3",
          d - a, 3);
    check(e - a == 5, "R6 bank 0 revisit", e - a, 5);

    // R8 undersized writes accepted at once while the bank is busy
    send(1, 0, 20'h00000, 4'd0, a);
    send(1, 2, 20'h00000, 4'd9, c);
    send(1, 3, 20'h00004, 4'd10, d);
    idle_drain();
    check(c - a == 1 && d - c == 1, "R8 small write accepted", d - a, 2);

    // R10/R9 reorder buffer limit on a read stream
    send(0, 0, 20'h00200, 4'd11, a);
    send(0, 0, 20'h00201, 4'd12, b);
    send(0, 0, 20'h00202, 4'd13, c);
    send(0, 0, 20'h00203, 4'd14, d);
    send(0, 0, 20'h00204, 4'd15, f);
    idle_drain();
    check(f - a == 6, "R10 fifth read stalls", f - a, 6);

    check(exp_iss.size() == 0, "R2 all issues seen", exp_iss.size(), 0);
    check(exp_rd.size() == 0, "R9 all reads returned", exp_rd.size(), 0);
    check(exp_err.size() == 0, "R8 all errors seen", exp_err.size(), 0);
    summary();
  end
endmodule